// File: doc/BRIEF.md
# Erased Page Detection Unit

This unit sits beside the read datapath of a flash controller and tells apart a page that has never been programmed from a page whose ECC decode failed. While a page streams past, it adds up the zero bits of every byte. The total covers the whole page and is never cleared at codeword boundaries. One cycle after the last byte, it looks at the uncorrectable flag from the external ECC decoder. If the decode failed and the zero total is strictly below a programmed threshold, the page is treated as erased. In that case the erased-page status bit is raised and the uncorrectable bit is left alone. Otherwise a failed decode raises the uncorrectable status bit. A page that decoded cleanly raises neither bit.

Software programs the erase threshold and a correction-strength field through a small register port. It reads and clears sticky status through the same port. A level interrupt is raised while any enabled status bit is set. Only the outcome is reported: no zero total and no bitflip count can be read. With the threshold at 1, only pages with no zero bit at all are taken as erased. A page with even one flipped bit falls through to the decoder's verdict.

The control path is a three-state machine.
- ST_IDLE: no page is in progress.
  - A start byte moves it to ST_ACCUM.
  - A byte flagged both start and end moves it to ST_DECIDE.
- ST_ACCUM: a page is being counted.
  - An end byte moves it to ST_DECIDE.
  - Any other byte keeps it in ST_ACCUM.
- ST_DECIDE: the one-cycle classification step.
  - A start byte in this cycle moves it to ST_ACCUM.
  - A start-and-end byte keeps it in ST_DECIDE.
  - Otherwise it returns to ST_IDLE.

Top module: `erased_page_detect`

## Requirements
- R1: The zero total of a page is the sum, over every byte from the start byte through the end byte inclusive, of 8 minus the byte's popcount. It is not cleared within a page, and a start byte reloads it with that byte's zeros alone.
- R2: When `ecc_uncorr` is 1 in the decision cycle and the zero total is strictly less than the threshold, status bit 16 (erased) is set and status bit 0 (uncorrectable) is not set.
- R3: When `ecc_uncorr` is 1 in the decision cycle and the zero total is greater than or equal to the threshold, status bit 0 is set and bit 16 is not set. A threshold of 0 never yields erased.
- R4: When `ecc_uncorr` is 0 in the decision cycle, neither status bit is set, whatever the zero total.
- R5: The configuration register is at address 0. Bits 4:0 hold the correction strength and bits 31:16 hold the erase threshold. All other bits read 0. The reset value is 0x00010000 (threshold 1, strength 0).
- R6: With threshold 1, a page containing a single zero bit is not classified as erased.
- R7: The zero total saturates at 65535 and does not wrap. A page of 8193 all-zero bytes with threshold 65535 is therefore not erased, while 8191 such bytes are erased.
- R8: The decision cycle is the cycle after the one carrying `page_end`. `ecc_uncorr` is sampled in that cycle. The status bit becomes readable after the clock edge that ends it, and not before.
- R9: Status (address 1; bit 0 uncorrectable, bit 16 erased) is sticky. Writing 1 to a bit clears it. Writing 0 leaves it unchanged. The reset value is 0.
- R10: `irq` equals the OR of status ANDed with the enable mask (address 2, bits 0 and 16, reset 0). The enable mask reads back with only those two bits.
- R11: A byte flagged `page_end` that arrives while no page is in progress causes no classification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | Data byte present this cycle |
| byte_data | input | 8 | Page data byte |
| page_start | input | 1 | Qualified by byte_valid: first byte of a page |
| page_end | input | 1 | Qualified by byte_valid: last byte of a page |
| ecc_uncorr | input | 1 | Uncorrectable flag from the ECC decoder, sampled in the decision cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 config, 1 status, 2 enable) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The bench goes after the threshold edge, where a total equal to the threshold must not count as erased. It also checks a threshold of 1 against a single zero bit. A design that compared with less-or-equal, or that cleared the total part way through the page, would report erased pages that are really corrupted. A run of 8193 all-zero bytes exposes a counter that wraps: the total would fold back to a small value and hide a dirty page as erased. Further tests check four things:
- a change of `ecc_uncorr` inside the decision cycle is honoured;
- a stray end byte outside a page is ignored;
- a write of 0 leaves status unchanged;
- masking of the interrupt works bit by bit.

A design with the sampling, ignoring, clearing or masking wrong would show a wrong or early status bit or a wrong `irq`.

// File: rtl/epd_pkg.sv
package epd_pkg;
    localparam int THR_W   = 16;
    localparam int STR_W   = 5;
    localparam int THR_LSB = 16;
    localparam int BIT_UNC = 0;
    localparam int BIT_ER  = 16;

    localparam logic [1:0] ADDR_CFG  = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_EN   = 2'd2;

    localparam logic [THR_W-1:0] THR_RST = 16'd1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCUM,
        ST_DECIDE
    } epd_state_e;
endpackage

// File: rtl/epd_zero_count.sv
module epd_zero_count #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              add,
    input  logic [DATA_W-1:0] data,
    output logic [CNT_W-1:0]  cnt
);
    localparam int ZW = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [ZW-1:0]    zeros;
    logic [CNT_W-1:0] base;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        zeros = '0;
        for (int i = 0; i < DATA_W; i++) begin
            zeros = zeros + {{(ZW-1){1'b0}}, ~data[i]};
        end
        base = load ? '0 : cnt_q;
        sum  = {1'b0, base} + {{(CNT_W+1-ZW){1'b0}}, zeros};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load || add) begin
            cnt_q <= sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
        end
    end

    assign cnt = cnt_q;

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (add && !load && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R7
endmodule

// File: rtl/epd_classify.sv
module epd_classify
    import epd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_valid,
    input  logic             page_start,
    input  logic             page_end,
    input  logic             ecc_uncorr,
    input  logic [CNT_W-1:0] cnt,
    input  logic [THR_W-1:0] thr,
    output logic             in_page,
    output logic             set_er,
    output logic             set_unc
);
    epd_state_e state_q, state_d;
    logic       below;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (byte_valid && page_start)
                    state_d = page_end ? ST_DECIDE : ST_ACCUM;
            end
            ST_ACCUM: begin
                if (byte_valid && page_end)
                    state_d = ST_DECIDE;
            end
            ST_DECIDE: begin
                if (byte_valid && page_start)
                    state_d = page_end ? ST_DECIDE : ST_ACCUM;
                else
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        below   = ({{(THR_W > CNT_W ? THR_W - CNT_W : 0){1'b0}}, cnt} < thr);
        in_page = (state_q == ST_ACCUM);
        set_er  = 1'b0;
        set_unc = 1'b0;
        if (state_q == ST_DECIDE) begin
            set_er  = ecc_uncorr && below;
            set_unc = ecc_uncorr && !below;
        end
    end

    AST_DECIDE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECIDE) |-> $past(byte_valid && page_end)); // R8
endmodule

// File: rtl/epd_regs.sv
module epd_regs
    import epd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    input  logic             set_er,
    input  logic             set_unc,
    output logic [31:0]      reg_rdata,
    output logic [THR_W-1:0] thr,
    output logic [1:0]       stat,
    output logic             irq
);
    logic [STR_W-1:0] str_q;
    logic [THR_W-1:0] thr_q;
    logic [1:0]       stat_q;
    logic [1:0]       en_q;
    logic [1:0]       wclr;
    logic             unused_wdata;

    assign unused_wdata = ^reg_wdata[15:STR_W];
    assign wclr = (reg_we && reg_addr == ADDR_STAT) ?
                  {reg_wdata[BIT_ER], reg_wdata[BIT_UNC]} : 2'b00;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            str_q  <= '0;
            thr_q  <= THR_RST;
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            if (reg_we && reg_addr == ADDR_CFG) begin
                str_q <= reg_wdata[STR_W-1:0];
                thr_q <= reg_wdata[THR_LSB +: THR_W];
            end
            if (reg_we && reg_addr == ADDR_EN)
                en_q <= {reg_wdata[BIT_ER], reg_wdata[BIT_UNC]};
            stat_q <= (stat_q & ~wclr) | {set_er, set_unc};
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CFG: begin
                reg_rdata[STR_W-1:0]         = str_q;
                reg_rdata[THR_LSB +: THR_W]  = thr_q;
            end
            ADDR_STAT: begin
                reg_rdata[BIT_UNC] = stat_q[0];
                reg_rdata[BIT_ER]  = stat_q[1];
            end
            ADDR_EN: begin
                reg_rdata[BIT_UNC] = en_q[0];
                reg_rdata[BIT_ER]  = en_q[1];
            end
            default: reg_rdata = '0;
        endcase
    end

    assign thr  = thr_q;
    assign stat = stat_q;
    assign irq  = |(stat_q & en_q);

    AST_STICKY_UNC: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[0] && !(reg_we && reg_addr == ADDR_STAT && reg_wdata[BIT_UNC]))
        |=> stat_q[0]); // R9
    AST_W1C_ER: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_STAT && reg_wdata[BIT_ER] && !set_er)
        |=> !stat_q[1]); // R9
endmodule

// File: rtl/erased_page_detect.sv
module erased_page_detect
    import epd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = THR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              page_start,
    input  logic              page_end,
    input  logic              ecc_uncorr,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    logic [CNT_W-1:0] cnt;
    logic [THR_W-1:0] thr;
    logic [1:0]       stat;
    logic             in_page, set_er, set_unc;
    logic             load, add;

    assign load = byte_valid && page_start;
    assign add  = byte_valid && in_page;

    epd_zero_count #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .add(add),
        .data(byte_data), .cnt(cnt)
    );

    epd_classify #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid),
        .page_start(page_start), .page_end(page_end),
        .ecc_uncorr(ecc_uncorr), .cnt(cnt), .thr(thr),
        .in_page(in_page), .set_er(set_er), .set_unc(set_unc)
    );

    epd_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .set_er(set_er), .set_unc(set_unc),
        .reg_rdata(reg_rdata), .thr(thr), .stat(stat), .irq(irq)
    );

    AST_ERASED_NEEDS_UNCORR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[1]) |-> $past(ecc_uncorr)); // R2
    AST_UNC_NEEDS_UNCORR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[0]) |-> $past(ecc_uncorr)); // R4
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !($rose(stat[0]) && $rose(stat[1]))); // R3
endmodule

// File: tb/sim_erased_page_detect.sv
module sim_erased_page_detect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        page_start = 1'b0;
    logic        page_end = 1'b0;
    logic        ecc_uncorr = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    erased_page_detect u0 (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .page_start(page_start), .page_end(page_end), .ecc_uncorr(ecc_uncorr),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    typedef struct packed {
        logic [7:0]  b;
        logic [15:0] n;
        logic [15:0] thr;
        logic        unc;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{8'hFF, 16'd16, 16'd1,   1'b1, 32'h0001_0000}, // R2 clean erased
        '{8'hFE, 16'd16, 16'd1,   1'b1, 32'h0000_0001}, // R6
        '{8'hFF, 16'd16, 16'd1,   1'b0, 32'h0000_0000}, // R4
        '{8'h00, 16'd4,  16'd33,  1'b1, 32'h0001_0000}, // R1 32<33
        '{8'h00, 16'd4,  16'd32,  1'b1, 32'h0000_0001}, // R3 32==32
        '{8'h0F, 16'd10, 16'd41,  1'b1, 32'h0001_0000}, // R1 40<41
        '{8'h00, 16'd4,  16'd0,   1'b1, 32'h0000_0001}, // R3 thr 0
        '{8'h00, 16'd2,  16'd100, 1'b0, 32'h0000_0000}  // R4 dirty, correctable
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = 32'h0;
    endtask

    task automatic drive(input logic [7:0] b, input logic s, input logic e, input logic u);
        @(negedge clk);
        byte_valid = 1'b1; byte_data = b; page_start = s; page_end = e; ecc_uncorr = u;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        byte_valid = 1'b0; page_start = 1'b0; page_end = 1'b0;
    endtask

    task automatic send_page(input logic [7:0] b, input int n, input logic u);
        for (int k = 0; k < n; k++) drive(b, k == 0, k == n - 1, u);
        idle_cycle();
        @(negedge clk);
    endtask

    logic [31:0] d;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(2'd0, d); chk("R5 cfg reset", d, 32'h0001_0000);
        rd(2'd1, d); chk("R9 status reset", d, 32'h0);
        rd(2'd2, d); chk("R10 enable reset", d, 32'h0);
        chk("R10 irq reset", {31'b0, irq}, 32'h0);

        wr(2'd0, 32'h1234_FFFF);
        rd(2'd0, d); chk("R5 cfg layout", d, 32'h1234_001F);

        for (int v = 0; v < 8; v++) begin
            wr(2'd0, {VEC[v].thr, 16'h0});
            send_page(VEC[v].b, int'(VEC[v].n), VEC[v].unc);
            rd(2'd1, d); chk($sformatf("R2 R3 R4 vector %0d", v), d, VEC[v].exp);
            wr(2'd1, 32'h0001_0001);
            ecc_uncorr = 1'b0;
        end

        // R1: start byte counted, mixed bytes: 8 zeros, thr 9 -> erased
        wr(2'd0, 32'h0009_0000);
        drive(8'h00, 1'b1, 1'b0, 1'b1);
        drive(8'hFF, 1'b0, 1'b0, 1'b1);
        drive(8'hFF, 1'b0, 1'b1, 1'b1);
        idle_cycle(); @(negedge clk);
        rd(2'd1, d); chk("R1 mixed bytes", d, 32'h0001_0000);
        wr(2'd1, 32'h0001_0001);

        // R1: restart reloads count: 8 zeros then restart with 0xFF page, thr 1
        wr(2'd0, 32'h0001_0000);
        drive(8'h00, 1'b1, 1'b0, 1'b1);
        drive(8'hFF, 1'b1, 1'b0, 1'b1);
        drive(8'hFF, 1'b0, 1'b1, 1'b1);
        idle_cycle(); @(negedge clk);
        rd(2'd1, d); chk("R1 restart reload", d, 32'h0001_0000);
        wr(2'd1, 32'h0001_0001);

        // R8: flag sampled in decision cycle, status not early
        drive(8'h00, 1'b1, 1'b1, 1'b0);
        idle_cycle();
        ecc_uncorr = 1'b1;
        rd(2'd1, d); chk("R8 not early", d, 32'h0);
        @(negedge clk);
        ecc_uncorr = 1'b0;
        rd(2'd1, d); chk("R8 decision sample", d, 32'h0000_0001);

        // R9: write 0 no effect; partial clear
        wr(2'd1, 32'h0);
        rd(2'd1, d); chk("R9 write 0", d, 32'h0000_0001);
        send_page(8'hFF, 2, 1'b1);
        rd(2'd1, d); chk("R9 sticky both", d, 32'h0001_0001);

        // R10: masking
        wr(2'd2, 32'hFFFF_FFFE);
        rd(2'd2, d); chk("R10 enable readback", d, 32'h0001_0000);
        chk("R10 irq erased enabled", {31'b0, irq}, 32'h1);
        wr(2'd1, 32'h0001_0000);
        rd(2'd1, d); chk("R9 partial clear", d, 32'h0000_0001);
        chk("R10 irq masked", {31'b0, irq}, 32'h0);
        wr(2'd2, 32'h0000_0001);
        chk("R10 irq unc enabled", {31'b0, irq}, 32'h1);
        wr(2'd1, 32'h0000_0001);
        chk("R10 irq after clear", {31'b0, irq}, 32'h0);
        wr(2'd2, 32'h0);

        // R11: stray end byte outside a page
        drive(8'h00, 1'b0, 1'b1, 1'b1);
        idle_cycle(); @(negedge clk);
        rd(2'd1, d); chk("R11 stray end", d, 32'h0);
        ecc_uncorr = 1'b0;

        // R7: saturation
        wr(2'd0, 32'hFFFF_0000);
        send_page(8'h00, 8191, 1'b1);
        rd(2'd1, d); chk("R7 below max erased", d, 32'h0001_0000);
        wr(2'd1, 32'h0001_0001);
        send_page(8'h00, 8193, 1'b1);
        rd(2'd1, d); chk("R7 saturate no wrap", d, 32'h0000_0001);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule